// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This shared functional unit holds a small file of base registers and serves fetch-and-add style prefix-sum requests from many thread processors in a single round. Every requester presents a valid bit, the index of a base register and an increment. One clock later each valid requester receives the value the base held "just before its turn", and the base has moved on by the sum of every increment aimed at it. When all increments are one, the returned values are distinct consecutive indices. That makes the unit suitable for compacting array elements or for handing out free slots without any lock.

Requests aimed at the same base are combined into one multi-operand operation. Their order is fixed as ascending requester index, so results can be predicted. Software should still assume only that each requester gets a slot of its own. Requests aimed at different bases are resolved independently in the same round. A master port can load any base register directly during cycles with no prefix-sum traffic. A combinational read port returns the current value of any base.

Top module: `ps_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every base register reads 0 and no response is valid.
- R2: `rsp_valid[i]` is high exactly one clock after `req_valid[i]` was high. The response occupies lane i of `rsp_data`, bits i*W to i*W+W-1.
- R3: A lone valid request on base b returns the value b held before that clock edge. After the edge, b reads the old value plus the increment.
- R4: Among valid requests to the same base in one cycle, requester i receives the old base plus the increments of all lower-index valid requesters on that base.
- R5: After a round, a base that received at least one valid request holds its old value plus the sum of all increments aimed at it.
- R6: Requests to different bases in the same cycle do not affect each other's results or bases.
- R7: All sums wrap modulo 2^W.
- R8: When k requesters on one base all use increment 1, they receive base, base+1, ..., base+k-1, and the base advances by k.
- R9: When `mst_we` is high and no request is valid, base `mst_idx` takes `mst_data` at the clock edge.
- R10: A master write made in a cycle with any valid request is dropped. Request-targeted bases still advance as in R5, and every other base keeps its value.
- R11: A base with no valid request and no accepted master write keeps its value.
- R12: A request whose valid bit is low adds nothing to any base or to any other requester's result, whatever its increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N | Per-requester request strobe |
| req_base | input | N*IW | Per-requester base register index, lane i at bits i*IW |
| req_inc | input | N*W | Per-requester increment, lane i at bits i*W |
| mst_we | input | 1 | Master direct-write strobe |
| mst_idx | input | IW | Master write target base |
| mst_data | input | W | Master write value |
| rd_idx | input | IW | Read port base index |
| rd_data | output | W | Current value of base `rd_idx` |
| rsp_valid | output | N | Per-requester response strobe, one cycle after the request |
| rsp_data | output | N*W | Per-requester old base value as seen in its serial slot |

## Verification
Directed rounds put a single request on one base, all requesters with increment one on a shared base, and mixed increments with an invalid lane carrying a large increment. These separate the base-only result, the slot ordering by index and the masking of invalid lanes. Rounds that spread requests over different bases show whether per-base grouping is exact. A load near the top of the range followed by increments shows whether wrap-around works. Master writes are tried both in idle cycles and in cycles that also carry requests, which exposes the priority rule. Constrained random rounds then mix all of these against a bench model of sequential fetch-and-add in index order.

// File: rtl/ps_pkg.sv
package ps_pkg;

    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_PS     = 2'd1,
        UPD_MASTER = 2'd2
    } upd_kind_e;

endpackage

// File: rtl/ps_prefix_scan.sv
module ps_prefix_scan #(
    parameter int N  = 4,
    parameter int NB = 4,
    parameter int W  = 16,
    parameter int IW = 2
) (
    input  logic [N-1:0]           valid,
    input  logic [N-1:0][IW-1:0]   base,
    input  logic [N-1:0][W-1:0]    inc,
    output logic [N-1:0][W-1:0]    excl,
    output logic [NB-1:0][W-1:0]   total,
    output logic [NB-1:0]          hit
);

    // exclusive prefix per requester over lower-index lanes on the same base
    for (genvar gi = 0; gi < N; gi++) begin : g_req
        logic [W-1:0] acc_d;
        always_comb begin
            acc_d = '0;
            for (int j = 0; j < gi; j++) begin
                if (valid[j] && (base[j] == base[gi])) begin
                    acc_d = acc_d + inc[j];
                end
            end
        end
        assign excl[gi] = acc_d;
    end

    // full sum and hit flag per base register
    for (genvar gb = 0; gb < NB; gb++) begin : g_base
        logic [W-1:0] sum_d;
        logic         hit_d;
        always_comb begin
            sum_d = '0;
            hit_d = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (valid[j] && (base[j] == IW'(gb))) begin
                    sum_d = sum_d + inc[j];
                    hit_d = 1'b1;
                end
            end
        end
        assign total[gb] = sum_d;
        assign hit[gb]   = hit_d;
    end

endmodule

// File: rtl/ps_base_regs.sv
module ps_base_regs
    import ps_pkg::*;
#(
    parameter int NB = 4,
    parameter int W  = 16,
    parameter int IW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NB-1:0]         ps_hit,
    input  logic [NB-1:0][W-1:0]  ps_total,
    input  logic                  any_req,
    input  logic                  mst_we,
    input  logic [IW-1:0]         mst_idx,
    input  logic [W-1:0]          mst_data,
    output logic [NB-1:0][W-1:0]  base_q
);

    typedef struct packed {
        logic [NB-1:0][W-1:0] base;
    } regs_t;

    regs_t     regs_d;
    regs_t     regs_q;
    upd_kind_e kind_d [NB];

    always_comb begin
        regs_d = regs_q;
        for (int b = 0; b < NB; b++) begin
            if (ps_hit[b]) begin
                kind_d[b] = UPD_PS;
            end else if (mst_we && !any_req && (mst_idx == IW'(b))) begin
                kind_d[b] = UPD_MASTER;
            end else begin
                kind_d[b] = UPD_HOLD;
            end
            case (kind_d[b])
                UPD_PS:     regs_d.base[b] = regs_q.base[b] + ps_total[b];
                UPD_MASTER: regs_d.base[b] = mst_data;
                default:    regs_d.base[b] = regs_q.base[b];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_q = regs_q.base;

endmodule

// File: rtl/ps_unit.sv
module ps_unit #(
    parameter int N  = 4,
    parameter int NB = 4,
    parameter int W  = 16,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [N*IW-1:0] req_base,
    input  logic [N*W-1:0]  req_inc,
    input  logic            mst_we,
    input  logic [IW-1:0]   mst_idx,
    input  logic [W-1:0]    mst_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [W-1:0]    rd_data,
    output logic [N-1:0]    rsp_valid,
    output logic [N*W-1:0]  rsp_data
);

    logic [N-1:0][IW-1:0] base_sel;
    logic [N-1:0][W-1:0]  inc_a;
    logic [N-1:0][W-1:0]  ps_excl;
    logic [NB-1:0][W-1:0] ps_total;
    logic [NB-1:0]        ps_hit;
    logic [NB-1:0][W-1:0] base_arr;
    logic                 any_req;

    assign base_sel = req_base;
    assign inc_a    = req_inc;
    assign any_req  = |req_valid;

    ps_prefix_scan #(.N(N), .NB(NB), .W(W), .IW(IW)) scan_i (
        .valid (req_valid),
        .base  (base_sel),
        .inc   (inc_a),
        .excl  (ps_excl),
        .total (ps_total),
        .hit   (ps_hit)
    );

    ps_base_regs #(.NB(NB), .W(W), .IW(IW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ps_hit   (ps_hit),
        .ps_total (ps_total),
        .any_req  (any_req),
        .mst_we   (mst_we),
        .mst_idx  (mst_idx),
        .mst_data (mst_data),
        .base_q   (base_arr)
    );

    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][W-1:0]  data;
    } rsp_t;

    rsp_t rsp_d;
    rsp_t rsp_q;

    always_comb begin
        rsp_d.vld = req_valid;
        for (int i = 0; i < N; i++) begin
            if (req_valid[i]) begin
                rsp_d.data[i] = base_arr[base_sel[i]] + ps_excl[i];
            end else begin
                rsp_d.data[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_data  = rsp_q.data;
    assign rd_data   = base_arr[rd_idx];

endmodule

// File: rtl/ps_unit_chk.sv
module ps_unit_chk #(
    parameter int N  = 4,
    parameter int NB = 4,
    parameter int W  = 16,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N-1:0]          req_valid,
    input logic [N*IW-1:0]       req_base,
    input logic                  mst_we,
    input logic [IW-1:0]         mst_idx,
    input logic [W-1:0]          mst_data,
    input logic [N-1:0]          rsp_valid,
    input logic [N*W-1:0]        rsp_data,
    input logic [NB-1:0][W-1:0]  base_arr,
    input logic [NB-1:0][W-1:0]  ps_total,
    input logic [NB-1:0]         ps_hit
);

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid)); // R2

    AST_FIRST_OLD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid[0] |-> rsp_data[W-1:0] == $past(base_arr[req_base[IW-1:0]])); // R3

    for (genvar gb = 0; gb < NB; gb++) begin : g_chk
        AST_BASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ps_hit[gb]) |-> base_arr[gb] == $past(base_arr[gb]) + $past(ps_total[gb])); // R5

        AST_MASTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mst_we) && ($past(req_valid) == '0) && ($past(mst_idx) == IW'(gb)))
            |-> base_arr[gb] == $past(mst_data)); // R9

        AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mst_we) && ($past(req_valid) != '0) && !$past(ps_hit[gb]))
            |-> $stable(base_arr[gb])); // R10

        AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(ps_hit[gb]) && !($past(mst_we) && ($past(mst_idx) == IW'(gb))))
            |-> $stable(base_arr[gb])); // R11
    end

endmodule

bind ps_unit ps_unit_chk #(.N(N), .NB(NB), .W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_base  (req_base),
    .mst_we    (mst_we),
    .mst_idx   (mst_idx),
    .mst_data  (mst_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .base_arr  (base_arr),
    .ps_total  (ps_total),
    .ps_hit    (ps_hit)
);

// File: tb/ps_unit_tb.sv
`timescale 1ns/1ps
module ps_unit_tb_top;

    localparam int N  = 4;
    localparam int NB = 4;
    localparam int W  = 16;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*IW-1:0] req_base = '0;
    logic [N*W-1:0]  req_inc = '0;
    logic            mst_we = 1'b0;
    logic [IW-1:0]   mst_idx = '0;
    logic [W-1:0]    mst_data = '0;
    logic [IW-1:0]   rd_idx = '0;
    logic [W-1:0]    rd_data;
    logic [N-1:0]    rsp_valid;
    logic [N*W-1:0]  rsp_data;

    int nchk = 0;
    int nfail = 0;
    logic [W-1:0] model [NB];

    always #4 clk = ~clk;

    ps_unit #(.N(N), .NB(NB), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_inc(req_inc), .mst_we(mst_we), .mst_idx(mst_idx), .mst_data(mst_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag, input string what);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_bases(input string tag);
        for (int b = 0; b < NB; b++) begin
            rd_idx = IW'(b);
            #0.5;
            chk(rd_data, model[b], tag, $sformatf("base %0d", b));
        end
    endtask

    // one round: inputs set by caller into the staging variables below
    logic [N-1:0]    s_v;
    logic [N*IW-1:0] s_b;
    logic [N*W-1:0]  s_i;
    logic            s_we;
    logic [IW-1:0]   s_idx;
    logic [W-1:0]    s_dat;

    task automatic do_round(input string tag);
        logic [W-1:0] exp_d [N];
        logic [W-1:0] nb [NB];
        logic         hit [NB];
        for (int b = 0; b < NB; b++) begin
            nb[b] = model[b];
            hit[b] = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            exp_d[i] = '0;
            if (s_v[i]) begin
                int bi = int'(s_b[i*IW +: IW]);
                exp_d[i] = nb[bi];
                nb[bi] = nb[bi] + s_i[i*W +: W];
                hit[bi] = 1'b1;
            end
        end
        if (s_we && (s_v == '0)) nb[s_idx] = s_dat;
        @(negedge clk);
        req_valid = s_v; req_base = s_b; req_inc = s_i;
        mst_we = s_we; mst_idx = s_idx; mst_data = s_dat;
        @(posedge clk);
        #1;
        req_valid = '0; mst_we = 1'b0;
        chk(W'(rsp_valid), W'(s_v), "R2", "rsp_valid");
        for (int i = 0; i < N; i++) begin
            if (s_v[i]) chk(rsp_data[i*W +: W], exp_d[i], tag, $sformatf("rsp lane %0d", i));
        end
        for (int b = 0; b < NB; b++) model[b] = nb[b];
        check_bases(tag);
    endtask

    task automatic set_req(input int i, input logic v, input int b, input logic [W-1:0] inc);
        s_v[i] = v;
        s_b[i*IW +: IW] = IW'(b);
        s_i[i*W +: W] = inc;
    endtask

    task automatic clear_stage();
        s_v = '0; s_b = '0; s_i = '0; s_we = 1'b0; s_idx = '0; s_dat = '0;
    endtask

    initial begin
        #(200000 * 8);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) model[b] = '0;
        clear_stage();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(W'(rsp_valid), '0, "R1", "rsp_valid after reset");
        check_bases("R1");

        // R3 single request
        clear_stage(); set_req(0, 1'b1, 2, 16'd5);
        do_round("R3");

        // R8 all increments one on shared base
        clear_stage();
        for (int i = 0; i < N; i++) set_req(i, 1'b1, 1, 16'd1);
        do_round("R8");

        // R4 / R12 mixed increments with invalid lane carrying a big increment
        clear_stage();
        set_req(0, 1'b1, 2, 16'd3); set_req(1, 1'b0, 2, 16'h4000);
        set_req(2, 1'b1, 2, 16'd7); set_req(3, 1'b1, 2, 16'd11);
        do_round("R12");
        clear_stage();
        set_req(0, 1'b1, 0, 16'd9); set_req(1, 1'b1, 0, 16'd2);
        set_req(2, 1'b1, 0, 16'd40); set_req(3, 1'b1, 0, 16'd1);
        do_round("R4");

        // R6 different bases interleaved
        clear_stage();
        set_req(0, 1'b1, 3, 16'd4); set_req(1, 1'b1, 1, 16'd6);
        set_req(2, 1'b1, 3, 16'd8); set_req(3, 1'b1, 0, 16'd10);
        do_round("R6");

        // R9 master load near top, then R7 wrap
        clear_stage(); s_we = 1'b1; s_idx = 2'd3; s_dat = 16'hFFFE;
        do_round("R9");
        clear_stage(); set_req(1, 1'b1, 3, 16'd3); set_req(2, 1'b1, 3, 16'd3);
        do_round("R7");

        // R10 master write dropped when requests present
        clear_stage(); set_req(0, 1'b1, 1, 16'd2);
        s_we = 1'b1; s_idx = 2'd2; s_dat = 16'h1234;
        do_round("R10");
        clear_stage(); set_req(3, 1'b1, 0, 16'd1);
        s_we = 1'b1; s_idx = 2'd0; s_dat = 16'hAAAA;
        do_round("R10");

        // R11 idle rounds hold bases
        clear_stage(); do_round("R11");
        clear_stage(); s_v[2] = 1'b0; s_i[2*W +: W] = 16'hFFFF; do_round("R11");

        // R5 constrained random rounds
        void'($urandom(32'd20240517));
        for (int r = 0; r < 400; r++) begin
            clear_stage();
            for (int i = 0; i < N; i++) begin
                logic [W-1:0] inc;
                inc = ($urandom % 4 == 0) ? W'($urandom) : W'($urandom % 8);
                set_req(i, ($urandom % 3) != 0, int'($urandom % NB), inc);
            end
            if ($urandom % 5 == 0) begin
                s_we = 1'b1; s_idx = IW'($urandom % NB); s_dat = W'($urandom);
                if ($urandom % 2 == 0) s_v = '0;
            end
            do_round("R5");
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule